// File: doc/BRIEF.md
# Dual-Channel Converter Serial Output Framer

This block models the device side of the serial data port of a two-channel, 12-bit sampling converter. Each channel's result arrives on its own parallel input. An active-low select and a serial clock come in from the host. On two data lines the block sends each result MSB first, padded with zero bits before and after. Each data line has its own output-enable, so the pad can three-state it. A status output shows whether the sampler is holding or tracking.

Every pin works in one system clock domain. The select and serial clock inputs pass through synchronisers and a registered edge detector. The results are latched when select falls, and that latch is the only point where the results are taken. There is no valid/ready handshake and no back-pressure. The host paces the frame with serial clock falling edges. It may stop a frame at any point by raising select. If it keeps select low for a full 32 falling edges, each line goes on to send the other channel's result.

The bit on a line is set by k, the number of serial clock falling edges counted since select fell. k is 0 right after select falls.

Top module: `adc_serial_framer`

## Requirements
- R1: A falling edge of select latches both channel results and sets hold to 1. It also sets both output-enables to 1 and k to 0. Input changes after that edge do not change the frame.
- R2: On each line, positions k = 0, 1, 2 are 0. Positions k = 3..14 carry the line's own channel MSB first, so k = 3 is bit 11 and k = 14 is bit 0. Line A's own channel is channel A, and line B's own channel is channel B.
- R3: Positions k = 15..18 are 0 on both lines.
- R4: Positions k = 19..30 carry the other channel MSB first, so k = 19 is bit 11 and k = 30 is bit 0. Position k = 31 is 0.
- R5: Hold stays 1 through the 13th falling edge. It returns to 0 on the first serial clock rising edge after that edge.
- R6: At the 32nd falling edge both output-enables drop to 0 and both data lines read 0. Further falling edges change nothing.
- R7: A serial clock falling edge that coincides with the select falling edge is not counted. The next falling edge is counted as the first.
- R8: A rising edge of select at any k drops both output-enables and sets hold to 0. A later select fall starts a fresh frame.
- R9: During and after reset, both output-enables, both data lines and hold are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select, asynchronous to clk |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| chan_a | input | 12 | Channel A result |
| chan_b | input | 12 | Channel B result |
| dout_a | output | 1 | Serial data line A (0 when disabled) |
| dout_a_oe | output | 1 | Output-enable of line A |
| dout_b | output | 1 | Serial data line B (0 when disabled) |
| dout_b_oe | output | 1 | Output-enable of line B |
| hold | output | 1 | 1 = holding, 0 = tracking |

## Verification
The bench changes both channel inputs right after each select fall. A design that sampled late would then show the inverted value mid-frame. It drives select and serial clock down in the same step. A design that counted that edge would put bit 10 on the line where bit 11 belongs. It checks hold right after the 13th falling edge and again after the following rising edge, which catches a track return one edge early or late. It also runs past 32 falling edges and aborts a frame at k = 7. Both runs catch lines that stay enabled or a counter that wraps instead of stopping.

// File: rtl/adc_framer_pkg.sv
package adc_framer_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SHIFT,
    FR_SPENT
  } fr_state_e;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_framer_pkg::*;
#(
  parameter int HOLD_FALLS = 13,
  parameter int MAX_FALLS  = 32,
  parameter int CNT_W      = $clog2(MAX_FALLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_fall,
  input  logic             sclk_rise,
  output logic [CNT_W-1:0] cnt,
  output logic             hold,
  output logic             shift_oe
);
  fr_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      cnt     <= '0;
      hold    <= 1'b0;
    end else if (cs_rise) begin
      state_q <= FR_IDLE;
      cnt     <= '0;
      hold    <= 1'b0;
    end else if (cs_fall) begin
      state_q <= FR_SHIFT;
      cnt     <= '0;
      hold    <= 1'b1;
    end else begin
      if (state_q == FR_SHIFT && sclk_fall) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(MAX_FALLS - 1)) state_q <= FR_SPENT;
      end
      if (state_q != FR_IDLE && sclk_rise && cnt >= CNT_W'(HOLD_FALLS))
        hold <= 1'b0;
    end
  end

  assign shift_oe = (state_q == FR_SHIFT);
endmodule

// File: rtl/adc_frame_lane.sv
module adc_frame_lane #(
  parameter int RES_W  = 12,
  parameter int CNT_W  = 6,
  parameter int OWN_LO = 3,
  parameter int OTH_LO = 19
) (
  input  logic             oe,
  input  logic [CNT_W-1:0] k,
  input  logic [RES_W-1:0] own,
  input  logic [RES_W-1:0] other,
  output logic             bit_o
);
  localparam int OWN_HI = OWN_LO + RES_W - 1;
  localparam int OTH_HI = OTH_LO + RES_W - 1;
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  always_comb begin
    bit_o = 1'b0;
    if (oe) begin
      if (k >= CNT_W'(OWN_LO) && k <= CNT_W'(OWN_HI))
        bit_o = |((own << (k - CNT_W'(OWN_LO))) & MSB);
      else if (k >= CNT_W'(OTH_LO) && k <= CNT_W'(OTH_HI))
        bit_o = |((other << (k - CNT_W'(OTH_LO))) & MSB);
    end
  end
endmodule

// File: rtl/adc_serial_framer.sv
module adc_serial_framer
  import adc_framer_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int LEAD_ZEROS  = 3,
  parameter int GAP_ZEROS   = 4,
  parameter int HOLD_FALLS  = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             ser_clk,
  input  logic [RES_W-1:0] chan_a,
  input  logic [RES_W-1:0] chan_b,
  output logic             dout_a,
  output logic             dout_a_oe,
  output logic             dout_b,
  output logic             dout_b_oe,
  output logic             hold
);
  localparam int MAX_FALLS = LEAD_ZEROS + RES_W + GAP_ZEROS + RES_W + 1;
  localparam int CNT_W     = $clog2(MAX_FALLS + 1);
  localparam int OTH_LO    = LEAD_ZEROS + RES_W + GAP_ZEROS;

  logic cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic [CNT_W-1:0] cnt;
  logic shift_oe;
  logic [RES_W-1:0] cap_q [LANES];
  logic [LANES-1:0] dout_w;

  adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sel_n), .rise(cs_rise), .fall(cs_fall)
  );

  adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .rise(sclk_rise), .fall(sclk_fall)
  );

  adc_frame_seq #(.HOLD_FALLS(HOLD_FALLS), .MAX_FALLS(MAX_FALLS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
    .cnt(cnt), .hold(hold), .shift_oe(shift_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q[0] <= '0;
      cap_q[1] <= '0;
    end else if (cs_fall) begin
      cap_q[0] <= chan_a;
      cap_q[1] <= chan_b;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    adc_frame_lane #(.RES_W(RES_W), .CNT_W(CNT_W), .OWN_LO(LEAD_ZEROS), .OTH_LO(OTH_LO)) u_lane (
      .oe(shift_oe), .k(cnt), .own(cap_q[i]), .other(cap_q[LANES-1-i]), .bit_o(dout_w[i])
    );
  end

  assign dout_a    = dout_w[0];
  assign dout_b    = dout_w[1];
  assign dout_a_oe = shift_oe;
  assign dout_b_oe = shift_oe;
endmodule

// File: rtl/adc_framer_chk.sv
module adc_framer_chk #(
  parameter int CNT_W      = 6,
  parameter int HOLD_FALLS = 13,
  parameter int MAX_FALLS  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic             sclk_fall,
  input logic             sclk_rise,
  input logic [CNT_W-1:0] cnt,
  input logic             hold,
  input logic             dout_a_oe,
  input logic             dout_b_oe,
  input logic             dout_a,
  input logic             dout_b
);
  // R1
  cs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall && !cs_rise |=> dout_a_oe && dout_b_oe && hold && cnt == '0);

  // R8
  cs_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !dout_a_oe && !dout_b_oe && !hold);

  // R7
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall && sclk_fall && !cs_rise |=> cnt == '0);

  // R6
  spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_W'(MAX_FALLS) |-> !dout_a_oe && !dout_b_oe && !dout_a && !dout_b);

  // R5
  track_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(cs_rise || (sclk_rise && cnt >= CNT_W'(HOLD_FALLS))));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !cs_rise && cnt < CNT_W'(HOLD_FALLS) |=> hold);

  // R2
  fall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_a_oe && sclk_fall && !cs_fall && !cs_rise |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));
endmodule

bind adc_serial_framer adc_framer_chk #(
  .CNT_W(CNT_W), .HOLD_FALLS(HOLD_FALLS), .MAX_FALLS(MAX_FALLS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .cnt(cnt), .hold(hold),
  .dout_a_oe(dout_a_oe), .dout_b_oe(dout_b_oe), .dout_a(dout_a), .dout_b(dout_b)
);

// File: tb/adc_serial_framer_bench.sv
module adc_serial_framer_bench;
  localparam int HALF = 6;
  localparam int NVEC = 6;
  localparam logic [23:0] VEC [NVEC] = '{
    24'hA5C_3F0, 24'hFFF_000, 24'h000_FFF, 24'h801_7FE, 24'h5A5_A5A, 24'h123_ED9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic ser_clk = 1'b1;
  logic [11:0] chan_a = '0;
  logic [11:0] chan_b = '0;
  logic dout_a, dout_a_oe, dout_b, dout_b_oe, hold;
  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  adc_serial_framer u_adc_serial_framer (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
    .chan_a(chan_a), .chan_b(chan_b),
    .dout_a(dout_a), .dout_a_oe(dout_a_oe), .dout_b(dout_b), .dout_b_oe(dout_b_oe),
    .hold(hold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (HALF) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic exp_bit(input int k, input logic [11:0] own, input logic [11:0] oth);
    logic [11:0] t;
    t = '0;
    if (k >= 3 && k <= 14) t = own >> (14 - k);
    else if (k >= 19 && k <= 30) t = oth >> (30 - k);
    return t[0];
  endfunction

  function automatic string tag_for(input int k);
    if (k <= 14) return "R1/R2";
    if (k <= 18) return "R3";
    return "R4";
  endfunction

  task automatic run_frame(input logic [11:0] a, input logic [11:0] b, input int n);
    chan_a = a; chan_b = b;
    settle();
    sel_n = 1'b0;
    settle();
    check("R1 oe", {30'd0, dout_a_oe, dout_b_oe}, 32'd3);
    check("R1 hold", {31'd0, hold}, 32'd1);
    check("R2 k0", {30'd0, dout_a, dout_b}, 32'd0);
    chan_a = ~a; chan_b = ~b;
    for (int i = 1; i <= n; i++) begin
      ser_clk = 1'b0;
      settle();
      if (i < 32) begin
        check(tag_for(i), {30'd0, dout_a, dout_b}, {30'd0, exp_bit(i, a, b), exp_bit(i, b, a)});
        check("R6 oe", {30'd0, dout_a_oe, dout_b_oe}, 32'd3);
      end else begin
        check("R6 spent", {28'd0, dout_a_oe, dout_b_oe, dout_a, dout_b}, 32'd0);
      end
      check("R5 at fall", {31'd0, hold}, {31'd0, (i <= 13)});
      ser_clk = 1'b1;
      settle();
      check("R5 at rise", {31'd0, hold}, {31'd0, (i < 13)});
    end
    sel_n = 1'b1;
    settle();
    check("R8 close", {29'd0, dout_a_oe, dout_b_oe, hold}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 in reset", {27'd0, dout_a_oe, dout_b_oe, dout_a, dout_b, hold}, 32'd0);
    rst_n = 1'b1;
    settle();
    check("R9 after reset", {27'd0, dout_a_oe, dout_b_oe, dout_a, dout_b, hold}, 32'd0);

    for (int v = 0; v < NVEC; v++) run_frame(VEC[v][23:12], VEC[v][11:0], 32);

    // R8: abort at k = 7, then a fresh frame
    run_frame(12'hF0F, 12'h0F0, 7);
    run_frame(12'h3C3, 12'hC3C, 16);

    // R6: falls past the 32nd
    run_frame(12'hFFF, 12'hFFF, 34);

    // R7: coincident select and serial clock falling edges
    chan_a = 12'h800; chan_b = 12'h001;
    settle();
    sel_n = 1'b0; ser_clk = 1'b0;
    settle();
    check("R7 k0", {30'd0, dout_a, dout_b}, 32'd0);
    ser_clk = 1'b1;
    settle();
    for (int i = 1; i <= 3; i++) begin
      ser_clk = 1'b0;
      settle();
      ser_clk = 1'b1;
      settle();
    end
    check("R7 msb at third fall", {30'd0, dout_a, dout_b}, 32'd2);
    sel_n = 1'b1;
    settle();
    check("R8 after R7", {29'd0, dout_a_oe, dout_b_oe, hold}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule